// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Responder

This block plays the device side of a three-wire serial EEPROM that only answers reads. It watches chip select, serial clock and serial data in, passes them through a short synchronizer clocked by the system clock, and finds the rising edges of the serial clock. Zero bits that arrive before the first one are ignored. The first one bit is the start bit, and two more bits complete the command. A read is followed by an address whose width is set by a parameter: 6 bits for a 64-word part or 8 bits for a 256-word part.

Straight after the last address bit, the responder drives a single zero on data out. A host can count the address bits it has shifted until that zero appears, and so work out the width of the part. The 16-bit word then follows, most significant bit first. Whenever the responder is not driving, data out sits at one, as a pulled-up line that nobody drives would.

The stored words come from a small register array. Logic on the chip writes that array through a parallel load port, one word per system clock.

Top module: `mwr_read_responder`

## Requirements
- R1: After reset, data out is 1, the responder is idle and every stored word reads as 0x0000.
- R2: While chip select is high and no command has started, bits of value 0 on data in are ignored. The first 1 is taken as the start bit.
- R3: A read command is the three bits 1,1,0 (start bit first) on data in, sampled on rising serial clock edges.
- R4: After a read command, the next ADDR_W bits form the word address, most significant bit first.
- R5: Data out is 1 for as long as the start bit, the command and the address are being received.
- R6: The rising edge that carries the last address bit makes data out 0 (the dummy zero), and data out stays 0 until the next rising edge.
- R7: Each of the next 16 rising edges presents one bit of the addressed word on data out, from bit 15 down to bit 0. Each bit is held until the following rising edge.
- R8: The rising edge after bit 0 returns data out to 1, and data out stays 1 until chip select drops.
- R9: When chip select goes low at any point, the responder returns to idle and data out becomes 1.
- R10: A command other than 1,1,0 is ignored: data out stays 1 on every later edge until chip select drops.
- R11: A system clock cycle with the load enable high writes the load data into the word at the load address, and later reads return it.
- R12: The word is copied when its address completes. A load to the same word while that word is being shifted out does not change the bits still to be sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ee_cs | input | 1 | Serial chip select, active high |
| ee_sk | input | 1 | Serial clock from the host |
| ee_di | input | 1 | Serial data in (command and address) |
| ee_do | output | 1 | Serial data out; 1 while not driven |
| ld_en | input | 1 | Load enable for the word array |
| ld_addr | input | ADDR_W | Load word address |
| ld_data | input | WORD_W | Load word value |

## Verification
Two paths can act on the same word at once: the serial path reading a word out, and the load port writing that word. The bench starts a read of a word, collects four bits, and then loads a new value into the same address while the serial clock is low. It checks that the remaining twelve bits still come from the old value, and that a second read afterwards returns the new one. It also lets chip select fall while data is being shifted out and checks that data out goes back to one and that the next read is unaffected.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start bit
        ST_OPC  = 3'd1,   // receiving the two opcode bits after start
        ST_ADDR = 3'd2,   // receiving address bits
        ST_DATA = 3'd3,   // shifting out the word
        ST_HOLD = 3'd4    // ignoring the rest until select drops
    } mwr_state_e;

    // Synchronized view of the serial lines
    typedef struct packed {
        logic cs;
        logic di;
        logic sk_rise;
    } mwr_line_t;

    localparam logic       START_BIT = 1'b1;
    localparam logic [1:0] OPC_READ  = 2'b10;   // bits after the start bit
    localparam logic       LINE_IDLE = 1'b1;    // level of an undriven line

    function automatic logic opc_is_read(input logic [1:0] opc);
        return opc == OPC_READ;
    endfunction

endpackage

// File: rtl/mwr_line_sync.sv
module mwr_line_sync
    import mwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_in,
    input  logic      sk_in,
    input  logic      di_in,
    output mwr_line_t line
);

    logic cs_s, sk_s, di_s;
    logic sk_prev;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign cs_s = cs_in;
            assign sk_s = sk_in;
            assign di_s = di_in;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] cs_ff, sk_ff, di_ff;
            for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        cs_ff[s] <= 1'b0;
                        sk_ff[s] <= 1'b0;
                        di_ff[s] <= 1'b0;
                    end else if (s == 0) begin
                        cs_ff[s] <= cs_in;
                        sk_ff[s] <= sk_in;
                        di_ff[s] <= di_in;
                    end else begin
                        cs_ff[s] <= cs_ff[(s == 0) ? 0 : s-1];
                        sk_ff[s] <= sk_ff[(s == 0) ? 0 : s-1];
                        di_ff[s] <= di_ff[(s == 0) ? 0 : s-1];
                    end
                end
            end
            assign cs_s = cs_ff[SYNC_STAGES-1];
            assign sk_s = sk_ff[SYNC_STAGES-1];
            assign di_s = di_ff[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sk_prev <= 1'b0;
        else     sk_prev <= sk_s;
    end

    always_comb begin
        line.cs      = cs_s;
        line.di      = di_s;
        line.sk_rise = sk_s & ~sk_prev;
    end

endmodule

// File: rtl/mwr_word_store.sv
module mwr_word_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    mem[w] <= '0;
                else if (ld_en && (ld_addr == ADDR_W'(w)))
                    mem[w] <= ld_data;
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
    import mwr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(ADDR_W + WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  mwr_line_t         line,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout,
    output mwr_state_e        state,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(WORD_W);

    logic [ADDR_W-1:0] addr_sh;
    logic              opc_hi;
    logic [WORD_W-1:0] word_sh;

    // address formed by the bits so far plus the bit on the current edge
    assign rd_addr = {addr_sh[ADDR_W-2:0], line.di};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            addr_sh <= '0;
            opc_hi  <= 1'b0;
            word_sh <= '0;
            dout    <= LINE_IDLE;
        end else if (!line.cs) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            dout    <= LINE_IDLE;
        end else if (line.sk_rise) begin
            case (state)
                ST_IDLE: begin
                    if (line.di == START_BIT) begin
                        state   <= ST_OPC;
                        bit_cnt <= '0;
                    end
                end
                ST_OPC: begin
                    if (bit_cnt == '0) begin
                        opc_hi  <= line.di;
                        bit_cnt <= CNT_W'(1);
                    end else begin
                        bit_cnt <= '0;
                        state   <= opc_is_read({opc_hi, line.di}) ? ST_ADDR : ST_HOLD;
                    end
                end
                ST_ADDR: begin
                    addr_sh <= rd_addr;
                    if (bit_cnt == ADDR_LAST) begin
                        state   <= ST_DATA;
                        bit_cnt <= '0;
                        dout    <= 1'b0;
                        word_sh <= rd_data;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_cnt == DATA_END) begin
                        state   <= ST_HOLD;
                        bit_cnt <= '0;
                        dout    <= LINE_IDLE;
                    end else begin
                        dout    <= word_sh[WORD_W-1];
                        word_sh <= {word_sh[WORD_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    dout <= LINE_IDLE;
                end
                default: begin
                    state   <= ST_IDLE;
                    bit_cnt <= '0;
                    dout    <= LINE_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/mwr_read_responder.sv
module mwr_read_responder
    import mwr_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ee_cs,
    input  logic              ee_sk,
    input  logic              ee_di,
    output logic              ee_do,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data
);

    localparam int CNT_W = $clog2(ADDR_W + WORD_W + 1);

    mwr_line_t         line_s;
    logic              cs_s;
    logic              rise_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    mwr_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;

    assign cs_s   = line_s.cs;
    assign rise_s = line_s.sk_rise;

    mwr_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_in(ee_cs),
        .sk_in(ee_sk),
        .di_in(ee_di),
        .line (line_s)
    );

    mwr_word_store #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) i_store (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_addr(ld_addr),
        .ld_data(ld_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    mwr_seq #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) i_seq (
        .clk    (clk),
        .rst    (rst),
        .line   (line_s),
        .rd_data(rd_data),
        .rd_addr(rd_addr),
        .dout   (ee_do),
        .state  (state),
        .bit_cnt(bit_cnt)
    );

endmodule

// File: rtl/mwr_read_responder_chk.sv
module mwr_read_responder_chk
    import mwr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_s,
    input logic             rise_s,
    input logic             dout,
    input mwr_state_e       state,
    input logic [CNT_W-1:0] bit_cnt
);

    // R9
    cs_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (dout && state == ST_IDLE));

    // R5
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_OPC || state == ST_ADDR) |-> dout);

    // R10
    ignored_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> dout);

    // R6
    dummy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_ADDR) |-> !dout);

    // R7
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_s && !rise_s) |=> $stable(dout));

    // R8
    data_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (bit_cnt <= CNT_W'(WORD_W)));

endmodule

bind mwr_read_responder mwr_read_responder_chk #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (cs_s),
    .rise_s (rise_s),
    .dout   (ee_do),
    .state  (state),
    .bit_cnt(bit_cnt)
);

// File: tb/test_mwr_read_responder.sv
`timescale 1ns/1ps
module test_mwr_read_responder;

    localparam int AW = 6;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic          dout;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [WW-1:0] ld_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mwr_read_responder #(.ADDR_W(AW), .WORD_W(WW), .SYNC_STAGES(2)) i_mwr_read_responder (
        .clk(clk), .rst(rst), .ee_cs(cs), .ee_sk(sk), .ee_di(di), .ee_do(dout),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One serial bit: data set while clock low, sampled late in clock-high phase
    task automatic clk_bit(input logic b, output logic seen);
        @(negedge clk); di = b;
        repeat (3) @(negedge clk);
        sk = 1'b1;
        repeat (10) @(negedge clk);
        seen = dout;
        sk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off(input string tag);
        @(negedge clk); cs = 1'b0; di = 1'b0;
        repeat (8) @(negedge clk);
        check(dout === 1'b1, tag, 32'(dout), 32'h1);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [WW-1:0] d);
        @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic send_cmd(input logic [2:0] op, input string tag);
        logic s;
        for (int i = 2; i >= 0; i--) begin
            clk_bit(op[i], s);
            check(s === 1'b1, tag, 32'(s), 32'h1);
        end
    endtask

    // Address phase; the last address bit must show the dummy zero
    task automatic send_addr(input logic [AW-1:0] a);
        logic s;
        for (int i = AW - 1; i >= 0; i--) begin
            clk_bit(a[i], s);
            if (i != 0) check(s === 1'b1, "R4/R5 address bit line high", 32'(s), 32'h1);
            else        check(s === 1'b0, "R6 dummy zero after last address bit", 32'(s), 32'h0);
        end
    endtask

    task automatic read_word(input logic [AW-1:0] a, input logic [WW-1:0] exp, input int lead0, input string tag);
        logic s;
        logic [WW-1:0] got;
        cs_on();
        for (int i = 0; i < lead0; i++) begin
            clk_bit(1'b0, s);
            check(s === 1'b1, "R2 leading zero ignored", 32'(s), 32'h1);
        end
        send_cmd(3'b110, "R3/R5 read command line high");
        send_addr(a);
        for (int i = WW - 1; i >= 0; i--) begin
            clk_bit(1'b0, s);
            got[i] = s;
        end
        check(got === exp, tag, 32'(got), 32'(exp));
        clk_bit(1'b0, s);
        check(s === 1'b1, "R8 line high after last data bit", 32'(s), 32'h1);
        clk_bit(1'b1, s);
        check(s === 1'b1, "R8 line stays high", 32'(s), 32'h1);
        cs_off("R9 idle after select drop");
    endtask

    task automatic t_reset();
        check(dout === 1'b1, "R1 data out after reset", 32'(dout), 32'h1);
        read_word(6'd3, 16'h0000, 0, "R1 array cleared by reset");
    endtask

    task automatic t_basic_reads();
        load(6'd0,  16'h8001);
        load(6'd63, 16'h7FFE);
        load(6'd42, 16'hA5C3);
        read_word(6'd0,  16'h8001, 0, "R7 word at address 0");
        read_word(6'd63, 16'h7FFE, 0, "R7 word at address 63");
        read_word(6'd42, 16'hA5C3, 0, "R4 R11 word at address 42");
    endtask

    task automatic t_leading_zeros();
        read_word(6'd42, 16'hA5C3, 3, "R2 read after leading zeros");
    endtask

    task automatic t_bad_opcode(input logic [2:0] op);
        logic s;
        int highs;
        cs_on();
        send_cmd(op, "R10 bad command line high");
        highs = 0;
        for (int i = 0; i < 24; i++) begin
            clk_bit(i[0], s);
            if (s === 1'b1) highs++;
        end
        check(highs == 24, "R10 ignored command keeps line high", 32'(highs), 32'd24);
        cs_off("R9 idle after ignored command");
        read_word(6'd63, 16'h7FFE, 0, "R10 normal read after ignored command");
    endtask

    task automatic t_cs_drop();
        logic s;
        logic [4:0] part;
        cs_on();
        send_cmd(3'b110, "R9 command line high");
        send_addr(6'd42);
        for (int i = 4; i >= 0; i--) begin
            clk_bit(1'b0, s);
            part[i] = s;
        end
        check(part === 5'b10100, "R7 first five bits before select drop", 32'(part), 32'h14);
        cs_off("R9 line high after drop mid data");
        cs_on();
        send_cmd(3'b110, "R9 command line high");
        clk_bit(1'b1, s);
        check(s === 1'b1, "R9 address bit line high", 32'(s), 32'h1);
        cs_off("R9 line high after drop mid address");
        read_word(6'd42, 16'hA5C3, 0, "R9 full read after aborted ones");
    endtask

    task automatic t_load_during_read();
        logic s;
        logic [WW-1:0] got;
        load(6'd9, 16'h1234);
        cs_on();
        send_cmd(3'b110, "R12 command line high");
        send_addr(6'd9);
        for (int i = WW - 1; i >= WW - 4; i--) begin
            clk_bit(1'b0, s);
            got[i] = s;
        end
        load(6'd9, 16'hFFFF);
        for (int i = WW - 5; i >= 0; i--) begin
            clk_bit(1'b0, s);
            got[i] = s;
        end
        check(got === 16'h1234, "R12 copied word unchanged by load", 32'(got), 32'h1234);
        cs_off("R9 idle after read");
        read_word(6'd9, 16'hFFFF, 0, "R11 new word after load");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic_reads();
        t_leading_zeros();
        t_bad_opcode(3'b101);
        t_bad_opcode(3'b111);
        t_cs_drop();
        t_load_during_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule